// File: doc/BRIEF.md
# MII Converter Port Control Bank

This block is the configuration register bank for a group of media-interface converter ports. Software reaches it through a simple memory-mapped read/write bus. Each port has a control register that picks the interface type (MII, RMII or RGMII), the link speed and the duplex setting. A shared release register keeps each port's converter in reset until software sets that port's bit.

Two further registers carry values for neighbouring logic. The first is a routing-mode code for the port multiplexing fabric. The second is a word of link-indication level bits, arranged as one active-low group and two active-high groups. The block does not convert any data. It decodes the stored settings into one-hot mode and speed selects, a duplex flag and a converter-enable for each port, and it drives the routing and link-level words out unchanged.

Writes take effect at the clock edge that accepts them. Reads return data one cycle after the read strobe. Software changes fields by read-modify-write, so every implemented bit reads back as it was stored, and every bit without a function reads as zero.

Top module: `mii_conv_top`

## Requirements
- R1: After reset, every register reads zero. Every port's enable is low, its mode select shows MII and its speed select shows 10 Mb/s.
- R2: A port control register sits at 0x100 + 4*port. Bits [1:0] hold the speed, bits [3:2] hold the interface, and bit 8 holds full duplex. Only these bits read back; all other bits read zero.
- R3: When a write to a port control register puts interface code 0 (MII) in bits [3:2], the stored speed becomes 0. It reads back as 0 and decodes as 10 Mb/s, whatever speed value was written.
- R4: The mode select of each port is a 3-bit one-hot: bit0 for MII (code 0), bit1 for RMII (code 1), bit2 for RGMII (code 2). The speed select is also 3-bit one-hot: bit0 for 10 Mb/s (code 0), bit1 for 100 Mb/s (code 1), bit2 for 1000 Mb/s (code 2).
- R5: A port's full-duplex output follows bit 8 of its control register.
- R6: The release register at 0x114 holds one bit per port in bits [NUM_PORTS-1:0], with bit n belonging to port n. A port's enable is high only when its release bit is set and both of its codes are valid.
- R7: Code 3 in either the interface field or the speed field is reserved. A reserved code makes that field's one-hot select all zero and holds the port's enable low, even when the port is released.
- R8: The routing-mode register at 0x008 stores bits [4:0]. It reads back with all higher bits at zero and drives the routing-mode output.
- R9: The link-level register at 0x014 stores bits [11:0]. Bits [3:0] form the active-low group and bits [11:4] form two active-high groups. The register reads back these bits and drives the link-level output.
- R10: A write to an unmapped or misaligned address changes no register. A read from such an address returns zero.
- R11: Read data appears in the cycle after the read strobe. Read data is zero in any cycle that follows a cycle without a read strobe.
- R12: When a read and a write hit the same register in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, registered |
| portModeSel | output | 3*NUM_PORTS | One-hot interface select per port |
| portSpeedSel | output | 3*NUM_PORTS | One-hot speed select per port |
| portFullDuplex | output | NUM_PORTS | Full-duplex flag per port |
| portEnable | output | NUM_PORTS | Converter enable per port |
| routeMode | output | ROUTE_W | Routing-mode code |
| linkLevel | output | LINK_W | Link-indication level bits |

## Verification
The bench writes MII together with a nonzero speed. A design that stored the speed unchanged would read back 1000 Mb/s on an MII port. It writes reserved codes into each field of released ports. A design that decoded code 3 as a real mode would raise an enable on a port whose setting is invalid. It writes to the misaligned address 0x101, to the address just past the last port, and to 0x000. A design with a loose address compare would corrupt port 0 or the release register. A same-cycle read and write of one register checks that the read returns the value from before the write rather than the new value.

// File: rtl/mii_conv_pkg.sv
package mii_conv_pkg;

  localparam int PORT_IDX_W = 3;

  localparam int OFS_ROUTE     = 'h008;
  localparam int OFS_LINK      = 'h014;
  localparam int OFS_PORT_BASE = 'h100;
  localparam int OFS_RELEASE   = 'h114;

  localparam int SPD_LO  = 0;
  localparam int MODE_LO = 2;
  localparam int FDX_BIT = 8;

  localparam logic [1:0] IF_MII   = 2'd0;
  localparam logic [1:0] IF_RMII  = 2'd1;
  localparam logic [1:0] IF_RGMII = 2'd2;
  localparam logic [1:0] SPD_10   = 2'd0;
  localparam logic [1:0] SPD_100  = 2'd1;
  localparam logic [1:0] SPD_1000 = 2'd2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ROUTE,
    SEL_LINK,
    SEL_RELEASE,
    SEL_PORT
  } regSel_e;

  typedef struct packed {
    logic                  wr;
    logic                  rd;
    regSel_e               sel;
    logic [PORT_IDX_W-1:0] portIdx;
  } cfgStrobe_t;

  typedef struct packed {
    logic       fdx;
    logic [1:0] mode;
    logic [1:0] speed;
  } portCtrl_t;

endpackage

// File: rtl/mii_conv_decode.sv
module mii_conv_decode
  import mii_conv_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int ADDR_W    = 12
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output cfgStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] ROUTE_A   = ADDR_W'(OFS_ROUTE);
  localparam logic [ADDR_W-1:0] LINK_A    = ADDR_W'(OFS_LINK);
  localparam logic [ADDR_W-1:0] RELEASE_A = ADDR_W'(OFS_RELEASE);
  localparam logic [ADDR_W-1:0] PORT_A    = ADDR_W'(OFS_PORT_BASE);
  localparam logic [ADDR_W-1:0] PORT_END  = ADDR_W'(OFS_PORT_BASE + 4 * NUM_PORTS);

  regSel_e               sel;
  logic [PORT_IDX_W-1:0] portIdx;

  always_comb begin
    sel     = SEL_NONE;
    portIdx = '0;
    if (addr == RELEASE_A) begin
      sel = SEL_RELEASE;
    end else if (addr == ROUTE_A) begin
      sel = SEL_ROUTE;
    end else if (addr == LINK_A) begin
      sel = SEL_LINK;
    end else if (addr >= PORT_A && addr < PORT_END && addr[1:0] == 2'b00) begin
      sel     = SEL_PORT;
      portIdx = PORT_IDX_W'((addr - PORT_A) >> 2);
    end
  end

  assign strobe.wr      = wrEn && (sel != SEL_NONE);
  assign strobe.rd      = rdEn;
  assign strobe.sel     = sel;
  assign strobe.portIdx = portIdx;

endmodule

// File: rtl/mii_conv_regs.sv
module mii_conv_regs
  import mii_conv_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int DATA_W    = 32,
  parameter int ROUTE_W   = 5,
  parameter int LINK_W    = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  cfgStrobe_t             strobe,
  input  logic [DATA_W-1:0]      wrData,
  output logic [DATA_W-1:0]      rdData,
  output logic [3*NUM_PORTS-1:0] portModeSel,
  output logic [3*NUM_PORTS-1:0] portSpeedSel,
  output logic [NUM_PORTS-1:0]   portFullDuplex,
  output logic [NUM_PORTS-1:0]   portEnable,
  output logic [ROUTE_W-1:0]     routeMode,
  output logic [LINK_W-1:0]      linkLevel
);

  localparam int CTRL_W = FDX_BIT + 1;

  logic [ROUTE_W-1:0]                routeReg;
  logic [LINK_W-1:0]                 linkReg;
  logic [NUM_PORTS-1:0]              releaseReg;
  logic [NUM_PORTS-1:0][DATA_W-1:0]  portWord;
  logic [DATA_W-1:0]                 portRd;
  logic                              unusedWrBits;

  assign unusedWrBits = ^wrData[DATA_W-1:LINK_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      routeReg   <= '0;
      linkReg    <= '0;
      releaseReg <= '0;
    end else if (strobe.wr) begin
      case (strobe.sel)
        SEL_ROUTE:   routeReg   <= wrData[ROUTE_W-1:0];
        SEL_LINK:    linkReg    <= wrData[LINK_W-1:0];
        SEL_RELEASE: releaseReg <= wrData[NUM_PORTS-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    portCtrl_t ctrlQ;
    logic      hit;
    logic [2:0] modeOh;
    logic [2:0] speedOh;

    assign hit = strobe.wr && (strobe.sel == SEL_PORT) &&
                 (strobe.portIdx == PORT_IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrlQ <= '0;
      end else if (hit) begin
        ctrlQ.fdx   <= wrData[FDX_BIT];
        ctrlQ.mode  <= wrData[MODE_LO +: 2];
        ctrlQ.speed <= (wrData[MODE_LO +: 2] == IF_MII) ? SPD_10 : wrData[SPD_LO +: 2];
      end
    end

    always_comb begin
      case (ctrlQ.mode)
        IF_MII:   modeOh = 3'b001;
        IF_RMII:  modeOh = 3'b010;
        IF_RGMII: modeOh = 3'b100;
        default:  modeOh = 3'b000;
      endcase
      case (ctrlQ.speed)
        SPD_10:   speedOh = 3'b001;
        SPD_100:  speedOh = 3'b010;
        SPD_1000: speedOh = 3'b100;
        default:  speedOh = 3'b000;
      endcase
    end

    assign portModeSel[3*i +: 3]  = modeOh;
    assign portSpeedSel[3*i +: 3] = speedOh;
    assign portFullDuplex[i]      = ctrlQ.fdx;
    assign portEnable[i]          = releaseReg[i] && (|modeOh) && (|speedOh);
    assign portWord[i] = DATA_W'({ctrlQ.fdx, {(CTRL_W - 5){1'b0}}, ctrlQ.mode, ctrlQ.speed});
  end

  always_comb begin
    portRd = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (strobe.portIdx == PORT_IDX_W'(i)) portRd = portWord[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !strobe.rd) begin
      rdData <= '0;
    end else begin
      case (strobe.sel)
        SEL_ROUTE:   rdData <= DATA_W'(routeReg);
        SEL_LINK:    rdData <= DATA_W'(linkReg);
        SEL_RELEASE: rdData <= DATA_W'(releaseReg);
        SEL_PORT:    rdData <= portRd;
        default:     rdData <= '0;
      endcase
    end
  end

  assign routeMode = routeReg;
  assign linkLevel = linkReg;

endmodule

// File: rtl/mii_conv_top.sv
module mii_conv_top
  import mii_conv_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int ROUTE_W   = 5,
  parameter int LINK_W    = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wrData,
  output logic [DATA_W-1:0]      rdData,
  output logic [3*NUM_PORTS-1:0] portModeSel,
  output logic [3*NUM_PORTS-1:0] portSpeedSel,
  output logic [NUM_PORTS-1:0]   portFullDuplex,
  output logic [NUM_PORTS-1:0]   portEnable,
  output logic [ROUTE_W-1:0]     routeMode,
  output logic [LINK_W-1:0]      linkLevel
);

  cfgStrobe_t strobe;

  mii_conv_decode #(
    .NUM_PORTS(NUM_PORTS),
    .ADDR_W   (ADDR_W)
  ) u_decode (
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .addr  (addr),
    .strobe(strobe)
  );

  mii_conv_regs #(
    .NUM_PORTS(NUM_PORTS),
    .DATA_W   (DATA_W),
    .ROUTE_W  (ROUTE_W),
    .LINK_W   (LINK_W)
  ) u_regs (
    .clk           (clk),
    .rst           (rst),
    .strobe        (strobe),
    .wrData        (wrData),
    .rdData        (rdData),
    .portModeSel   (portModeSel),
    .portSpeedSel  (portSpeedSel),
    .portFullDuplex(portFullDuplex),
    .portEnable    (portEnable),
    .routeMode     (routeMode),
    .linkLevel     (linkLevel)
  );

endmodule

// File: rtl/mii_conv_checker.sv
module mii_conv_checker #(
  parameter int NUM_PORTS = 5,
  parameter int DATA_W    = 32,
  parameter int ROUTE_W   = 5
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wrEn,
  input logic                   rdEn,
  input logic [DATA_W-1:0]      rdData,
  input logic [3*NUM_PORTS-1:0] portModeSel,
  input logic [3*NUM_PORTS-1:0] portSpeedSel,
  input logic [NUM_PORTS-1:0]   portEnable,
  input logic [ROUTE_W-1:0]     routeMode
);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
    a_r4_mode_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(portModeSel[3*i +: 3]));

    a_r4_speed_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(portSpeedSel[3*i +: 3]));

    a_r7_enable_valid: assert property (@(posedge clk) disable iff (rst)
      portEnable[i] |-> ($countones(portModeSel[3*i +: 3]) == 1 &&
                         $countones(portSpeedSel[3*i +: 3]) == 1));

    a_r3_mii_speed_zero: assert property (@(posedge clk) disable iff (rst)
      portModeSel[3*i] |-> (portSpeedSel[3*i +: 3] == 3'b001));
  end

  a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> (rdData == '0));

  a_r8_route_hold: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> $stable(routeMode));

endmodule

bind mii_conv_top mii_conv_checker #(
  .NUM_PORTS(NUM_PORTS),
  .DATA_W   (DATA_W),
  .ROUTE_W  (ROUTE_W)
) u_checker (
  .clk         (clk),
  .rst         (rst),
  .wrEn        (wrEn),
  .rdEn        (rdEn),
  .rdData      (rdData),
  .portModeSel (portModeSel),
  .portSpeedSel(portSpeedSel),
  .portEnable  (portEnable),
  .routeMode   (routeMode)
);

// File: tb/test_mii_conv_top.sv
module test_mii_conv_top;

  localparam int NP = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [14:0]   portModeSel;
  logic [14:0]   portSpeedSel;
  logic [4:0]    portFullDuplex;
  logic [4:0]    portEnable;
  logic [4:0]    routeMode;
  logic [11:0]   linkLevel;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mii_conv_top i_mii_conv_top (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .portModeSel(portModeSel),
    .portSpeedSel(portSpeedSel), .portFullDuplex(portFullDuplex),
    .portEnable(portEnable), .routeMode(routeMode), .linkLevel(linkLevel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  function automatic logic [31:0] modeOf(input int p);
    return 32'(portModeSel[3*p +: 3]);
  endfunction

  function automatic logic [31:0] speedOf(input int p);
    return 32'(portSpeedSel[3*p +: 3]);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h008, d); check("R1 route reset", d, 0);
    rd(12'h014, d); check("R1 link reset", d, 0);
    rd(12'h114, d); check("R1 release reset", d, 0);
    for (int p = 0; p < NP; p++) begin
      rd(12'(12'h100 + 4 * p), d); check("R1 port reset", d, 0);
      check("R1 mode MII after reset", modeOf(p), 32'b001);
      check("R1 speed 10 after reset", speedOf(p), 32'b001);
    end
    check("R1 enables low", 32'(portEnable), 0);
  endtask

  task automatic t_port_fields();
    logic [31:0] d;
    wr(12'h108, 32'hFFFF_F105);
    rd(12'h108, d); check("R2 port2 readback", d, 32'h105);
    check("R4 port2 mode RMII", modeOf(2), 32'b010);
    check("R4 port2 speed 100", speedOf(2), 32'b010);
    check("R5 port2 full duplex", 32'(portFullDuplex[2]), 1);
    check("R6 port2 not released", 32'(portEnable), 0);
  endtask

  task automatic t_mii_speed();
    logic [31:0] d;
    wr(12'h100, 32'h0000_0002);
    rd(12'h100, d); check("R3 MII speed reads 0", d, 32'h0);
    check("R3 MII speed decodes 10", speedOf(0), 32'b001);
    check("R4 port0 mode MII", modeOf(0), 32'b001);
    check("R5 port0 half duplex", 32'(portFullDuplex[0]), 0);
  endtask

  task automatic t_release();
    logic [31:0] d;
    wr(12'h114, 32'hFFFF_FFE4);
    rd(12'h114, d); check("R6 release readback", d, 32'h04);
    check("R6 only port2 enabled", 32'(portEnable), 32'b00100);
    wr(12'h110, 32'h0000_010A);
    rd(12'h110, d); check("R2 port4 readback", d, 32'h10A);
    check("R4 port4 mode RGMII", modeOf(4), 32'b100);
    check("R4 port4 speed 1000", speedOf(4), 32'b100);
    wr(12'h114, 32'h0000_0014);
    check("R6 ports 2 and 4 enabled", 32'(portEnable), 32'b10100);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(12'h104, 32'h0000_0007);
    wr(12'h10C, 32'h0000_000D);
    wr(12'h114, 32'h0000_001F);
    rd(12'h104, d); check("R7 port1 readback", d, 32'h07);
    rd(12'h10C, d); check("R7 port3 readback", d, 32'h0D);
    check("R7 port1 speed reserved", speedOf(1), 0);
    check("R7 port1 mode RMII", modeOf(1), 32'b010);
    check("R7 port3 mode reserved", modeOf(3), 0);
    check("R7 reserved ports disabled", 32'(portEnable), 32'b10101);
  endtask

  task automatic t_route_link();
    logic [31:0] d;
    wr(12'h008, 32'hFFFF_FFF6);
    rd(12'h008, d); check("R8 route readback", d, 32'h16);
    check("R8 route output", 32'(routeMode), 32'h16);
    wr(12'h014, 32'hABCD_E5A3);
    rd(12'h014, d); check("R9 link readback", d, 32'h5A3);
    check("R9 link output", 32'(linkLevel), 32'h5A3);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(12'h101, 32'hFFFF_FFFF);
    wr(12'h118, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h0FC, 32'hFFFF_FFFF);
    rd(12'h100, d); check("R10 port0 untouched", d, 32'h0);
    rd(12'h104, d); check("R10 port1 untouched", d, 32'h07);
    rd(12'h114, d); check("R10 release untouched", d, 32'h1F);
    rd(12'h008, d); check("R10 route untouched", d, 32'h16);
    rd(12'h014, d); check("R10 link untouched", d, 32'h5A3);
    rd(12'h118, d); check("R10 unmapped reads 0", d, 0);
    rd(12'h101, d); check("R10 misaligned reads 0", d, 0);
    check("R10 enables unchanged", 32'(portEnable), 32'b10101);
  endtask

  task automatic t_read_timing();
    logic [31:0] d;
    @(negedge clk);
    rdEn = 1'b1; addr = 12'h014;
    @(negedge clk);
    rdEn = 1'b0;
    check("R11 data one cycle after strobe", rdData, 32'h5A3);
    @(negedge clk);
    check("R11 data zero without strobe", rdData, 0);
    @(negedge clk);
    rdEn = 1'b1; wrEn = 1'b1; addr = 12'h008; wrData = 32'h3;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
    check("R12 same-cycle read returns old value", rdData, 32'h16);
    rd(12'h008, d); check("R12 write landed", d, 32'h3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_port_fields();
    t_mii_speed();
    t_release();
    t_reserved();
    t_route_link();
    t_unmapped();
    t_read_timing();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule